// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block generates a periodic interrupt from the core clock. An 8-bit scale value sets a prescaler that divides the clock. It holds n-1 for a divide-by-n tick. Each tick moves a 16-bit down counter. When a tick finds the counter at zero, the counter reloads from a 16-bit period register and the block emits a one-cycle interrupt pulse. Software programs the scale, period and count, and starts or stops the timer, through a small register port with one write strobe and a combinational read path.

A two-state controller gates all timing activity. In state `ST_STOP` the prescaler and the counter hold their values. In state `ST_RUN` the prescaler counts and issues ticks. Two transitions are defined. `GO` moves `ST_STOP` to `ST_RUN` when the control register is written with bit 0 set. `HALT` moves `ST_RUN` to `ST_STOP` when it is written with bit 0 clear. Any other control write keeps the current state. Direct writes to the count always take effect, whatever the state. A write to the period changes only the value used at the next reload.

Top module: `interval_timer`

## Requirements
- R1: After reset, the count, period, scale and enable all read as 0, the controller is in `ST_STOP`, and `irq` is low.
- R2: Register select `reg_addr` takes these values: 0 is the count, 1 is the period, 2 is the scale in bits 7:0 with the upper bits read as 0, and 3 is the control register with the enable in bit 0. A write occurs on the rising clock edge while `reg_wr` is high. `reg_rdata` shows the selected register combinationally.
- R3: In `ST_RUN` with scale s, a tick occurs every s+1 clock cycles. Writing the scale restarts the prescaler, so the first tick after the write comes s+1 running cycles later. A scale of 0 ticks on every running cycle.
- R4: A tick with a nonzero count decrements the count by one.
- R5: A tick with a count of zero loads the period into the count, and `irq` is high in the following cycle.
- R6: `irq` is high for exactly one cycle for each expiry, and it is never high without a preceding expiry.
- R7: A period of 0 keeps the count at 0 and produces an interrupt on every tick.
- R8: In `ST_STOP` neither the prescaler nor the count changes, and `irq` stays low.
- R9: A write to the count appears in the next cycle in any state. It overrides a coinciding tick, and that tick raises no interrupt.
- R10: A write to the period leaves the current count unchanged. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The assertions assume that `reg_wr` and `reg_addr` are never unknown once reset is released. They also assume that a write lasts exactly one clock edge, so each write is a single event. The stimulus changes inputs only on the falling clock edge and keeps the strobe high across exactly one rising edge. It also configures scale, period and count only while the timer is stopped, except in the directed cases that test writes during a run on purpose.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic run
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctrl_wr && ctrl_bit)  state_d = ST_RUN;   // GO
            ST_RUN:  if (ctrl_wr && !ctrl_bit) state_d = ST_STOP;  // HALT
            default: state_d = ST_STOP;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SCL_W-1:0] restart_val,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);

    logic [SCL_W-1:0] pre_q;

    assign tick = run && (pre_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= restart_val;
        end else if (run) begin
            if (pre_q == '0) pre_q <= scale;
            else             pre_q <= pre_q - SCL_W'(1);
        end
    end

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    logic at_zero;
    assign at_zero = (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= tick && at_zero && !load_en;
            if (load_en)      count <= load_val;
            else if (tick) begin
                if (at_zero)  count <= period;
                else          count <= count - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             run,
    output logic [CNT_W-1:0] reg_rdata,
    output logic [CNT_W-1:0] period,
    output logic [SCL_W-1:0] scale,
    output logic             wr_count,
    output logic             wr_scale,
    output logic             wr_ctrl
);

    reg_sel_e sel;
    assign sel      = reg_sel_e'(reg_addr);
    assign wr_count = reg_wr && (sel == SEL_COUNT);
    assign wr_scale = reg_wr && (sel == SEL_SCALE);
    assign wr_ctrl  = reg_wr && (sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= '0;
            scale  <= '0;
        end else begin
            if (reg_wr && sel == SEL_PERIOD) period <= reg_wdata;
            if (wr_scale)                     scale  <= reg_wdata[SCL_W-1:0];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_COUNT:  reg_rdata = count;
            SEL_PERIOD: reg_rdata = period;
            SEL_SCALE:  reg_rdata = CNT_W'(scale);
            SEL_CTRL:   reg_rdata = CNT_W'(run);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);

    logic             run, tick;
    logic             wr_count, wr_scale, wr_ctrl;
    logic [CNT_W-1:0] period, count;
    logic [SCL_W-1:0] scale;

    timer_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .count(count), .run(run),
        .reg_rdata(reg_rdata), .period(period), .scale(scale),
        .wr_count(wr_count), .wr_scale(wr_scale), .wr_ctrl(wr_ctrl)
    );

    timer_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl),
        .ctrl_bit(reg_wdata[0]), .run(run)
    );

    timer_prescaler #(.SCL_W(SCL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(wr_scale),
        .restart_val(reg_wdata[SCL_W-1:0]), .scale(scale), .tick(tick)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(wr_count),
        .load_val(reg_wdata), .period(period), .count(count), .irq(irq)
    );

endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic             wr_count,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             irq
);

    // R4
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != '0 && !wr_count) |=> count == $past(count) - CNT_W'(1));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0 && !wr_count) |=> (irq && count == $past(period)));

    // R6
    no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && count == '0 && !wr_count) |=> !irq);

    // R8
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(count));

    // R8
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    // R9
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> (count == $past(reg_wdata) && !irq));

endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wr_count(wr_count),
    .reg_wdata(reg_wdata), .count(count), .period(period), .irq(irq)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    interval_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {scale, period, initial count, running cycles}
    localparam int VEC [6][4] = '{
        '{0, 3, 2, 20},
        '{2, 1, 0, 30},
        '{0, 0, 0, 5},
        '{3, 4, 5, 60},
        '{255, 2, 1, 800},
        '{1, 0, 3, 17}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
        #1;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
        reg_addr = 2'd0;
    endtask

    function automatic int exp_irqs(int s, int p, int c, int n);
        int t = n / (s + 1);
        if (t < c + 1) return 0;
        return 1 + (t - c - 1) / (p + 1);
    endfunction

    function automatic int exp_count(int s, int p, int c, int n);
        int t = n / (s + 1);
        if (t <= c) return c - t;
        return p - ((t - c - 1) % (p + 1));
    endfunction

    task automatic setup(input int s, input int p, input int c);
        wr_reg(2'd3, 16'd0);
        wr_reg(2'd2, 16'(s));
        wr_reg(2'd1, 16'(p));
        wr_reg(2'd0, 16'(c));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int v, hits;
        repeat (3) @(negedge clk);
        // R1 reset values
        rd_reg(2'd0, v); check("R1 count", v, 0);
        rd_reg(2'd1, v); check("R1 period", v, 0);
        rd_reg(2'd2, v); check("R1 scale", v, 0);
        rd_reg(2'd3, v); check("R1 enable", v, 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(2'd0, v); check("R1 count after release", v, 0);
        check("R1 irq after release", int'(irq), 0);

        // R2 register map, scale upper bits dropped
        wr_reg(2'd2, 16'h01AB);
        rd_reg(2'd2, v); check("R2 scale readback", v, 16'h00AB);
        wr_reg(2'd1, 16'h1234);
        rd_reg(2'd1, v); check("R2 period readback", v, 16'h1234);

        // R3 R4 R5 R6 R7 vector walk
        foreach (VEC[i]) begin
            setup(VEC[i][0], VEC[i][1], VEC[i][2]);
            wr_reg(2'd3, 16'd1);
            hits = 0;
            for (int k = 0; k < VEC[i][3]; k++) begin
                @(negedge clk);
                if (irq) hits++;
            end
            rd_reg(2'd0, v);
            check("R5 R7 irq count", hits,
                  exp_irqs(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]));
            check("R3 R4 count", v,
                  exp_count(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]));
        end

        // R8 stopped: nothing moves
        setup(0, 5, 7);
        hits = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (irq) hits++;
        end
        rd_reg(2'd0, v); check("R8 count frozen", v, 7);
        check("R8 no irq while stopped", hits, 0);
        rd_reg(2'd3, v); check("R2 enable reads 0", v, 0);

        // R10 R5 R6 R9 directed sequence, scale 0
        setup(0, 2, 3);
        wr_reg(2'd3, 16'd1);
        rd_reg(2'd3, v); check("R2 enable reads 1", v, 1);
        @(negedge clk);                     // edge 1
        rd_reg(2'd0, v); check("R4 first decrement", v, 2);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'd9;
        @(negedge clk);                     // edge 2
        reg_wr = 1'b0; reg_addr = 2'd0;
        rd_reg(2'd0, v); check("R10 period write keeps count", v, 1);
        @(negedge clk);                     // edge 3
        rd_reg(2'd0, v); check("R4 reaches zero", v, 0);
        check("R6 no irq before expiry", int'(irq), 0);
        @(negedge clk);                     // edge 4
        rd_reg(2'd0, v); check("R10 reload uses new period", v, 9);
        check("R5 irq after expiry", int'(irq), 1);
        @(negedge clk);                     // edge 5
        check("R6 irq one cycle", int'(irq), 0);
        rd_reg(2'd0, v); check("R4 after reload", v, 8);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'd100;
        @(negedge clk);                     // edge 6
        reg_wr = 1'b0;
        rd_reg(2'd0, v); check("R9 direct count write", v, 100);
        @(negedge clk);                     // edge 7
        rd_reg(2'd0, v); check("R9 continues from written", v, 99);

        // R3 restart on scale write
        setup(3, 10, 10);
        wr_reg(2'd3, 16'd1);
        repeat (3) @(negedge clk);
        rd_reg(2'd0, v); check("R3 no tick before s+1", v, 10);
        @(negedge clk);
        rd_reg(2'd0, v); check("R3 tick at s+1", v, 9);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'd1;
        @(negedge clk);                     // edge 5, restart to 1
        reg_wr = 1'b0; reg_addr = 2'd0;
        rd_reg(2'd0, v); check("R3 restart no tick", v, 9);
        @(negedge clk);
        rd_reg(2'd0, v); check("R3 restart hold", v, 9);
        @(negedge clk);
        rd_reg(2'd0, v); check("R3 tick after restart", v, 8);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule